// File: doc/BRIEF.md
# Cycle Counter Performance Monitor

This block is the per-core register file for a free-running cycle counter used to profile software. An agent on the core reads and writes five register selects through a simple single-cycle access port. The selects cover a control register, a set port and a clear port for the counter enable, a user-access register and the 32-bit cycle count. The counter advances once per clock only while two independent enables are both on. These are a global enable in the control register and a per-counter enable that is set and cleared through its own ports. A self-clearing bit in the control register zeroes the count. Writing 5 to the control register therefore starts counting from zero in a single access.

Every access carries a privilege flag. Privileged accesses never fault. Unprivileged writes always fault and change nothing. Unprivileged reads are allowed only after privileged code sets the user-access bit; otherwise they fault and return zero. Each core holds its own instance, so the state is never shared.

Top module: `cyc_perfmon`

## Requirements
- R1: After reset, the control register (select 0) reads 0x41072000 with bit 0 clear. The enable register (selects 1 and 2), the user-access register (select 3) and the count (select 4) all read 0.
- R2: An unprivileged read while bit 0 of the user-access register is 0 raises `acc_fault` and returns 0. Once that bit is 1, unprivileged reads of any select return the register value with no fault.
- R3: A privileged access never raises `acc_fault`. An unprivileged write always raises `acc_fault` and leaves every register unchanged.
- R4: The count increases by exactly 1 on each clock where control bit 0 and enable bit 31 are both 1. In every other case it holds its value.
- R5: Writing a 1 to bit 31 through select 1 sets the counter enable, and writing a 0 there leaves it unchanged. Writing a 1 to bit 31 through select 2 clears it. Both selects read the enable back in bit 31.
- R6: Writing control bit 2 as 1 sets the count to 0 on the next clock, and that bit always reads back as 0. Writing the value 5 enables counting and clears the count in the same access.
- R7: When a count reset and an increment fall on the same clock, the reset wins and the count reads 0 afterwards.
- R8: The count wraps from 0xFFFFFFFF to 0 with no other effect.
- R9: A privileged write to select 4 loads the count with the write data.
- R10: Read data and `acc_fault` are valid in the same cycle as the access. A write cycle returns 0 on `acc_rdata`. Selects 5 to 7 read 0 without a fault, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the counted clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access valid this cycle |
| acc_sel | input | 3 | Register select (0 control, 1 enable set, 2 enable clear, 3 user access, 4 count) |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged agent |
| acc_rdata | output | 32 | Read data, same cycle |
| acc_fault | output | 1 | Access refused (undefined-instruction trap) |

## Verification
A counter reset written through the control register can land on the same clock as an increment. The bench provokes this by writing 5 while the counter is already running with both enables on. It then expects the next read to return exactly 0 and the read after it to return 1, so the increment is shown to have been dropped rather than applied after the clear. A second collision arises when the write that sets the global enable arrives while the counter is stopped. The bench loads 0xFFFFFFFE, turns on counting and judges the following reads against 0xFFFFFFFE, 0xFFFFFFFF and 0. This shows both that the enable takes effect one clock late and that the count wraps.

// File: rtl/cyc_pm_pkg.sv
package cyc_pm_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ENSET = 3'd1,
    SEL_ENCLR = 3'd2,
    SEL_USER  = 3'd3,
    SEL_COUNT = 3'd4
  } pm_sel_e;

  localparam int GLB_EN_BIT = 0;
  localparam int CLR_BIT    = 2;

  typedef struct packed {
    logic ctrl;
    logic enset;
    logic enclr;
    logic user;
    logic count;
  } pm_wr_s;
endpackage

// File: rtl/cyc_pm_access.sv
module cyc_pm_access
  import cyc_pm_pkg::*;
(
  input  logic       acc_en,
  input  logic [2:0] acc_sel,
  input  logic       acc_wr,
  input  logic       acc_priv,
  input  logic       user_ok,
  output pm_wr_s     wr_strb,
  output logic       rd_ok,
  output logic       fault
);
  pm_sel_e sel_e;
  logic    wr_ok;

  assign sel_e = pm_sel_e'(acc_sel);

  always_comb begin
    fault = acc_en && !acc_priv && (acc_wr || !user_ok);
    wr_ok = acc_en && acc_wr && acc_priv;
    rd_ok = acc_en && !acc_wr && !fault;
    wr_strb.ctrl  = wr_ok && (sel_e == SEL_CTRL);
    wr_strb.enset = wr_ok && (sel_e == SEL_ENSET);
    wr_strb.enclr = wr_ok && (sel_e == SEL_ENCLR);
    wr_strb.user  = wr_ok && (sel_e == SEL_USER);
    wr_strb.count = wr_ok && (sel_e == SEL_COUNT);
  end
endmodule

// File: rtl/cyc_pm_ctrl.sv
module cyc_pm_ctrl
  import cyc_pm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pm_wr_s            wr_strb,
  input  logic [DATA_W-1:0] wdata,
  output logic              glb_en_q,
  output logic              cnt_en_q,
  output logic              user_q,
  output logic              clr_pulse
);
  localparam int C_BIT = DATA_W - 1;

  logic glb_en_d, cnt_en_d, user_d;

  always_comb begin
    glb_en_d  = glb_en_q;
    cnt_en_d  = cnt_en_q;
    user_d    = user_q;
    clr_pulse = wr_strb.ctrl && wdata[CLR_BIT];
    if (wr_strb.ctrl)                   glb_en_d = wdata[GLB_EN_BIT];
    if (wr_strb.enset && wdata[C_BIT])  cnt_en_d = 1'b1;
    if (wr_strb.enclr && wdata[C_BIT])  cnt_en_d = 1'b0;
    if (wr_strb.user)                   user_d   = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      cnt_en_q <= 1'b0;
      user_q   <= 1'b0;
    end else begin
      glb_en_q <= glb_en_d;
      cnt_en_q <= cnt_en_d;
      user_q   <= user_d;
    end
  end
endmodule

// File: rtl/cyc_pm_counter.sv
module cyc_pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc_en,
  output logic [W-1:0] count_q
);
  logic [W-1:0] count_d;
  logic         ce;

  always_comb begin
    ce      = clr || load || inc_en;
    count_d = count_q;
    if (clr)         count_d = '0;
    else if (load)   count_d = load_val;
    else if (inc_en) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (ce)  count_q <= count_d;
  end
endmodule

// File: rtl/cyc_perfmon.sv
module cyc_perfmon
  import cyc_pm_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] CTRL_ID = 32'h4107_2000,
  parameter int          SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [2:0]        acc_sel,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_priv,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_fault
);
  localparam int C_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] ID_RO =
    DATA_W'(CTRL_ID) & ~((DATA_W'(1) << GLB_EN_BIT) | (DATA_W'(1) << CLR_BIT));

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_N-1];

  pm_wr_s            wr_strb;
  logic              rd_ok;
  logic              glb_en_q, cnt_en_q, user_q, clr_pulse;
  logic [DATA_W-1:0] count_q;
  pm_sel_e           sel_e;

  cyc_pm_access u_acc (
    .acc_en   (acc_en),
    .acc_sel  (acc_sel),
    .acc_wr   (acc_wr),
    .acc_priv (acc_priv),
    .user_ok  (user_q),
    .wr_strb  (wr_strb),
    .rd_ok    (rd_ok),
    .fault    (acc_fault)
  );

  cyc_pm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_strb   (wr_strb),
    .wdata     (acc_wdata),
    .glb_en_q  (glb_en_q),
    .cnt_en_q  (cnt_en_q),
    .user_q    (user_q),
    .clr_pulse (clr_pulse)
  );

  cyc_pm_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr_pulse),
    .load     (wr_strb.count),
    .load_val (acc_wdata),
    .inc_en   (glb_en_q && cnt_en_q),
    .count_q  (count_q)
  );

  assign sel_e = pm_sel_e'(acc_sel);

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) begin
      case (sel_e)
        SEL_CTRL:             acc_rdata = ID_RO | (DATA_W'(glb_en_q) << GLB_EN_BIT);
        SEL_ENSET, SEL_ENCLR: acc_rdata = DATA_W'(cnt_en_q) << C_BIT;
        SEL_USER:             acc_rdata = DATA_W'(user_q);
        SEL_COUNT:            acc_rdata = count_q;
        default:              acc_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cyc_pm_checker.sv
module cyc_pm_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic [2:0]        acc_sel,
  input logic              acc_wr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              acc_priv,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_fault,
  input logic              glb_en_q,
  input logic              cnt_en_q,
  input logic              user_q,
  input logic [DATA_W-1:0] count_q
);
  logic pwr;
  assign pwr = acc_en && acc_wr && acc_priv;

  AST_UNPRIV_WR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_priv) |-> acc_fault);  // R3
  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_priv) |-> !acc_fault);  // R3
  AST_USER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_priv && !user_q) |-> (acc_fault && acc_rdata == '0));  // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(glb_en_q && cnt_en_q) && !pwr) |=> $stable(count_q));  // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en_q && cnt_en_q && !pwr) |=> (count_q == $past(count_q) + 1'b1));  // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr && acc_sel == 3'd0 && acc_wdata[2]) |=> (count_q == '0));  // R7
  AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr) |-> (acc_rdata == '0));  // R10
endmodule

bind cyc_perfmon cyc_pm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_en    (acc_en),
  .acc_sel   (acc_sel),
  .acc_wr    (acc_wr),
  .acc_wdata (acc_wdata),
  .acc_priv  (acc_priv),
  .acc_rdata (acc_rdata),
  .acc_fault (acc_fault),
  .glb_en_q  (glb_en_q),
  .cnt_en_q  (cnt_en_q),
  .user_q    (user_q),
  .count_q   (count_q)
);

// File: tb/sim_cyc_perfmon.sv
module sim_cyc_perfmon;
  localparam int CLK_P = 10;
  localparam logic [31:0] ID = 32'h4107_2000;
  localparam logic [31:0] CB = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        acc_priv = 1'b0;
  logic [31:0] acc_rdata;
  logic        acc_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cyc_perfmon u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_rdata(acc_rdata), .acc_fault(acc_fault)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  sel;
    logic        wr;
    logic [31:0] wd;
    logic        priv;
    logic [31:0] exp_rd;
    logic        exp_flt;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 3'd0, 1'b0, 32'h0,      1'b1, ID,           1'b0}, // R1
    '{4'd1, 3'd3, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R1
    '{4'd1, 3'd1, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R1
    '{4'd1, 3'd4, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R1
    '{4'd2, 3'd4, 1'b0, 32'h0,      1'b0, 32'h0,        1'b1}, // R2
    '{4'd2, 3'd0, 1'b0, 32'h0,      1'b0, 32'h0,        1'b1}, // R2
    '{4'd3, 3'd3, 1'b1, 32'h1,      1'b0, 32'h0,        1'b1}, // R3
    '{4'd3, 3'd3, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R3
    '{4'd3, 3'd1, 1'b1, CB,         1'b0, 32'h0,        1'b1}, // R3
    '{4'd3, 3'd1, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R3
    '{4'd3, 3'd3, 1'b1, 32'h1,      1'b1, 32'h0,        1'b0}, // R3
    '{4'd2, 3'd3, 1'b0, 32'h0,      1'b1, 32'h1,        1'b0}, // R2
    '{4'd2, 3'd4, 1'b0, 32'h0,      1'b0, 32'h0,        1'b0}, // R2
    '{4'd9, 3'd4, 1'b1, 32'h1234,   1'b1, 32'h0,        1'b0}, // R9
    '{4'd9, 3'd4, 1'b0, 32'h0,      1'b0, 32'h1234,     1'b0}, // R9
    '{4'd3, 3'd4, 1'b1, 32'h5678,   1'b0, 32'h0,        1'b1}, // R3
    '{4'd3, 3'd4, 1'b0, 32'h0,      1'b1, 32'h1234,     1'b0}, // R3
    '{4'd5, 3'd1, 1'b1, 32'h0,      1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd1, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd1, 1'b1, CB,         1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd1, 1'b0, 32'h0,      1'b1, CB,           1'b0}, // R5
    '{4'd5, 3'd1, 1'b1, 32'h0,      1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd2, 1'b0, 32'h0,      1'b1, CB,           1'b0}, // R5
    '{4'd5, 3'd2, 1'b1, 32'h0,      1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd1, 1'b0, 32'h0,      1'b1, CB,           1'b0}, // R5
    '{4'd5, 3'd2, 1'b1, CB,         1'b1, 32'h0,        1'b0}, // R5
    '{4'd5, 3'd1, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R5
    '{4'd6, 3'd0, 1'b1, 32'h4,      1'b1, 32'h0,        1'b0}, // R6
    '{4'd6, 3'd4, 1'b0, 32'h0,      1'b1, 32'h0,        1'b0}, // R6
    '{4'd6, 3'd0, 1'b0, 32'h0,      1'b1, ID,           1'b0}, // R6
    '{4'd10, 3'd7, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0,    1'b0}, // R10
    '{4'd10, 3'd7, 1'b0, 32'h0,     1'b1, 32'h0,        1'b0}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] s, input logic w, input logic [31:0] d, input logic p,
                     output logic [31:0] rd, output logic f);
    @(negedge clk);
    acc_en = 1'b1; acc_sel = s; acc_wr = w; acc_wdata = d; acc_priv = p;
    #(CLK_P/4);
    rd = acc_rdata; f = acc_fault;
    @(posedge clk);
    #1;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, b;
    logic f;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].sel, VEC[i].wr, VEC[i].wd, VEC[i].priv, rd, f);
      chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rd, VEC[i].exp_rd);
      chk($sformatf("R%0d vec%0d fault", VEC[i].req, i), {31'b0, f}, {31'b0, VEC[i].exp_flt});
    end

    // R4: global enable on, counter enable off -> holds
    acc(3'd0, 1'b1, 32'h1, 1'b1, rd, f);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    repeat (3) @(posedge clk);
    acc(3'd4, 1'b0, 32'h0, 1'b1, b, f);
    chk("R4 hold with C off", b, a);
    // R4: counter enable on, global off -> holds
    acc(3'd0, 1'b1, 32'h0, 1'b1, rd, f);
    acc(3'd1, 1'b1, CB, 1'b1, rd, f);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    repeat (3) @(posedge clk);
    acc(3'd4, 1'b0, 32'h0, 1'b1, b, f);
    chk("R4 hold with E off", b, a);

    // R6: preload, then write 5 -> cleared and counting
    acc(3'd4, 1'b1, 32'h100, 1'b1, rd, f);
    acc(3'd0, 1'b1, 32'h5, 1'b1, rd, f);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R6 write 5 clears", a, 32'h0);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R6 write 5 enables", a, 32'h1);
    acc(3'd0, 1'b0, 32'h0, 1'b1, rd, f);
    chk("R6 ctrl readback E set, bit2 clear", rd, ID | 32'h1);

    // R4: rate of one per clock
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    repeat (4) @(posedge clk);
    acc(3'd4, 1'b0, 32'h0, 1'b1, b, f);
    chk("R4 increments per clock", b - a, 32'd5);

    // R7: clear collides with an increment
    acc(3'd0, 1'b1, 32'h5, 1'b1, rd, f);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R7 clear beats increment", a, 32'h0);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R7 resumes after clear", a, 32'h1);

    // R8: wrap
    acc(3'd0, 1'b1, 32'h0, 1'b1, rd, f);
    acc(3'd4, 1'b1, 32'hFFFF_FFFE, 1'b1, rd, f);
    acc(3'd0, 1'b1, 32'h1, 1'b1, rd, f);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R8 wrap step 0", a, 32'hFFFF_FFFE);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R8 wrap step 1", a, 32'hFFFF_FFFF);
    acc(3'd4, 1'b0, 32'h0, 1'b1, a, f);
    chk("R8 wrap step 2", a, 32'h0);

    // R1: reset mid-run returns everything to reset values
    do_reset();
    acc(3'd0, 1'b0, 32'h0, 1'b1, rd, f);
    chk("R1 ctrl after reset", rd, ID);
    acc(3'd1, 1'b0, 32'h0, 1'b1, rd, f);
    chk("R1 enable after reset", rd, 32'h0);
    acc(3'd3, 1'b0, 32'h0, 1'b1, rd, f);
    chk("R1 user after reset", rd, 32'h0);
    acc(3'd4, 1'b0, 32'h0, 1'b1, rd, f);
    chk("R1 count after reset", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule